// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller gathers a set of interrupt sources and drives two request lines toward a processor. The fast line has one source only: source 0, an external input. All other sources are ordered by a per-source priority level and drive the normal line. The next few sources after source 0 are external pins. The rest are on-chip peripheral lines. Each source has its own configuration word. The word holds a vector value, a priority level, a trigger mode and an enable bit.

Software services the normal line by reading the vector address. That read returns the vector of the winning source, clears its edge latch and pushes its level onto a hardware level stack. While that level is on top of the stack, only a strictly higher level can raise the normal line again, which gives nested preemption. A write to the end-of-interrupt address pops the stack. A read of the vector address while the normal line is low returns a programmable spurious value and changes no state.

The register port is a single-cycle port. Read data is combinational from the address. The side effects of reads and writes take place at the clock edge where the matching enable is high. With the default parameters the address map is:
- 0 to 31: the source configuration words.
- 32: vector read and acknowledge.
- 33: end of interrupt.
- 34: fast vector read.
- 35: spurious vector.

Top module: `vpic_top`

## Requirements
- R1: After reset both request lines are low, every configuration word reads 0, the stack is empty and the spurious vector register reads its reset value 0xFF.
- R2: A write to address i below the source count stores the configuration word of source i. A read of that address returns it. The fields are: vector in bits 7:0, level in bits 10:8, trigger mode in bits 12:11, enable in bit 13.
- R3: A source whose enable bit is 0 drives neither request line, whatever its input does.
- R4: The fast line follows only source 0, and source 0 never drives the normal line. A read of address 34 returns the vector of source 0 and clears its edge latch.
- R5: External sources (indices 1 to 4) decode the trigger mode as follows. 00 is high level, 01 is low level, 10 is rising edge and 11 is falling edge. A source in an edge mode stays pending until it is acknowledged.
- R6: Internal sources ignore bit 0 of the mode. They are high-level sensitive with mode 00 or 01, and rising-edge sensitive with mode 10 or 11.
- R7: Among the enabled pending sources, the highest level wins. On equal levels the lowest source index wins.
- R8: A read of address 32 while the normal line is high returns the winner's vector, clears the winner's edge latch and pushes the winner's level.
- R9: While the stack is not empty, the normal line is raised only by a pending source whose level is strictly above the top of the stack. This lets the stack reach a depth of eight nested levels.
- R10: A write to address 33 pops one entry, so the previous level becomes the threshold again. On an empty stack it does nothing.
- R11: A read of address 32 while the normal line is low returns the spurious vector register (address 35, writable) and pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (triggers read side effects) |
| addr_i | input | 6 | Register address |
| wdata_i | input | 14 | Register write data |
| rdata_o | output | 14 | Register read data, combinational from addr_i |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The bench builds the controller with its default parameters: 32 sources, 4 external lines, 8 levels and 8-bit vectors. It can therefore use every external trigger mode and the ignored polarity bit on internal sources. It can also stack one acknowledged source per level until all eight levels are nested. That reaches the full depth of the stack, the point where no level can preempt, and the unwinding by end-of-interrupt writes where a still-pending top-level source raises the line again.

// File: rtl/vpic_pkg.sv
// Shared types for the vectored priority interrupt controller.
// Assumes: mode codes are stored raw in the configuration word.
package vpic_pkg;
    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;
endpackage

// File: rtl/vpic_src.sv
// Per-source trigger detector. Turns one raw input into a pending flag,
// according to the trigger mode. Internal sources (EXTERNAL=0) ignore the
// polarity part of the mode. Assumes src_i is already synchronous to clk.
module vpic_src
    import vpic_pkg::*;
#(
    parameter bit EXTERNAL = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  src_i,
    input  trig_e mode_i,
    input  logic  clr_i,
    output logic  pend_o
);
    logic prev_q, latch_q;
    logic inv, is_edge, lvl, prev_lvl, edge_det;

    // Decode polarity and edge selection from the mode
    always_comb begin
        inv      = EXTERNAL && (mode_i == TRIG_LOW || mode_i == TRIG_FALL);
        is_edge  = (mode_i == TRIG_RISE) || (mode_i == TRIG_FALL);
        lvl      = src_i ^ inv;
        prev_lvl = prev_q ^ inv;
        edge_det = is_edge && lvl && !prev_lvl;
        pend_o   = is_edge ? latch_q : lvl;
    end

    // Track the previous input and hold edge events until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= src_i;
            if (edge_det)
                latch_q <= 1'b1;
            else if (clr_i)
                latch_q <= 1'b0;
        end
    end

    p_edge_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !edge_det) |=> !latch_q);
endmodule

// File: rtl/vpic_arb.sv
// Combinational priority selector. Picks the requesting source with the
// highest level. On equal levels the lowest index wins. Indices below FIRST
// are excluded. Assumes req_i is already masked by the enables.
module vpic_arb #(
    parameter int NUM_SRC = 32,
    parameter int LVL_W   = 3,
    parameter int FIRST   = 1,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [LVL_W-1:0]   prio_i [NUM_SRC],
    output logic               found_o,
    output logic [SRC_W-1:0]   sel_o,
    output logic [LVL_W-1:0]   lvl_o
);
    // Descending scan with >= so a lower index takes over on a tie
    always_comb begin
        found_o = 1'b0;
        sel_o   = '0;
        lvl_o   = '0;
        for (int i = NUM_SRC - 1; i >= FIRST; i--) begin
            if (req_i[i] && (!found_o || prio_i[i] >= lvl_o)) begin
                found_o = 1'b1;
                sel_o   = SRC_W'(i);
                lvl_o   = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/vpic_stack.sv
// Level stack for nested service. A push stores an acknowledged level and a
// pop restores the previous one. Assumes pushes come only with strictly
// higher levels, so DEPTH equal to the level count can never overflow.
module vpic_stack #(
    parameter int DEPTH  = 8,
    parameter int LVL_W  = 3,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [LVL_W-1:0] push_lvl_i,
    input  logic             pop_i,
    output logic             empty_o,
    output logic [LVL_W-1:0] top_o
);
    logic [LVL_W-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] wptr, tptr;

    // Pointers into the entry array
    always_comb begin
        wptr    = cnt_q[PTR_W-1:0];
        tptr    = wptr - 1'b1;
        empty_o = (cnt_q == '0);
        top_o   = mem_q[tptr];
    end

    // Entry count, with push taking precedence over pop
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push_i && cnt_q < CNT_W'(DEPTH))
            cnt_q <= cnt_q + 1'b1;
        else if (pop_i && !empty_o)
            cnt_q <= cnt_q - 1'b1;
    end

    // Entry storage, written on push only
    always_ff @(posedge clk) begin
        if (push_i && cnt_q < CNT_W'(DEPTH))
            mem_q[wptr] <= push_lvl_i;
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> cnt_q < CNT_W'(DEPTH));
    p_push_higher_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !empty_o) |-> push_lvl_i > top_o);
    p_pop_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/vpic_top.sv
// Vectored priority interrupt controller top. It holds the per-source
// configuration words and the spurious vector, instantiates one detector
// per source, the selector and the level stack, and decodes the register
// port. Assumes NUM_SRC is a power of two and src_i is synchronous.
module vpic_top
    import vpic_pkg::*;
#(
    parameter int          NUM_SRC  = 32,
    parameter int          NUM_EXT  = 4,
    parameter int          NUM_LVL  = 8,
    parameter int          VEC_W    = 8,
    parameter logic [7:0]  SPUR_RST = 8'hFF
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_SRC-1:0]                   src_i,
    input  logic                                 wr_en_i,
    input  logic                                 rd_en_i,
    input  logic [$clog2(NUM_SRC):0]             addr_i,
    input  logic [VEC_W+$clog2(NUM_LVL)+2:0]     wdata_i,
    output logic [VEC_W+$clog2(NUM_LVL)+2:0]     rdata_o,
    output logic                                 fiq_o,
    output logic                                 irq_o
);
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int ADDR_W  = SRC_W + 1;
    localparam int CFG_W   = VEC_W + LVL_W + 3;
    localparam int PRIO_LO = VEC_W;
    localparam int MODE_LO = VEC_W + LVL_W;
    localparam int EN_BIT  = VEC_W + LVL_W + 2;
    localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(NUM_SRC);
    localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(NUM_SRC + 1);
    localparam logic [ADDR_W-1:0] A_FVEC = ADDR_W'(NUM_SRC + 2);
    localparam logic [ADDR_W-1:0] A_SPUR = ADDR_W'(NUM_SRC + 3);

    logic [CFG_W-1:0]   cfg_q [NUM_SRC];
    logic [VEC_W-1:0]   spur_q;
    logic [NUM_SRC-1:0] pend, req;
    logic [LVL_W-1:0]   prio [NUM_SRC];
    logic               found, empty, ack, pop, fvec_rd, cfg_sel;
    logic [SRC_W-1:0]   sel;
    logic [LVL_W-1:0]   best_lvl, top_lvl;

    // Register-port strobes
    always_comb begin
        cfg_sel = (addr_i < ADDR_W'(NUM_SRC));
        ack     = rd_en_i && addr_i == A_VEC && irq_o;
        pop     = wr_en_i && addr_i == A_EOI;
        fvec_rd = rd_en_i && addr_i == A_FVEC;
    end

    // Configuration words and spurious vector storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= '0;
            spur_q <= SPUR_RST[VEC_W-1:0];
        end else if (wr_en_i) begin
            if (cfg_sel)
                cfg_q[addr_i[SRC_W-1:0]] <= wdata_i;
            else if (addr_i == A_SPUR)
                spur_q <= wdata_i[VEC_W-1:0];
        end
    end

    // One trigger detector per source, external ones honour polarity
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic clr;
        assign clr = (g == 0) ? fvec_rd : (ack && sel == SRC_W'(g));
        vpic_src #(.EXTERNAL((g <= NUM_EXT) ? 1'b1 : 1'b0)) u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[g]),
            .mode_i (trig_e'(cfg_q[g][MODE_LO+1:MODE_LO])),
            .clr_i  (clr),
            .pend_o (pend[g])
        );
        assign req[g]  = pend[g] && cfg_q[g][EN_BIT];
        assign prio[g] = cfg_q[g][PRIO_LO+LVL_W-1:PRIO_LO];
    end

    vpic_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .FIRST(1)) u_arb (
        .req_i   (req),
        .prio_i  (prio),
        .found_o (found),
        .sel_o   (sel),
        .lvl_o   (best_lvl)
    );

    vpic_stack #(.DEPTH(NUM_LVL), .LVL_W(LVL_W)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ack),
        .push_lvl_i (best_lvl),
        .pop_i      (pop),
        .empty_o    (empty),
        .top_o      (top_lvl)
    );

    // Request lines: fast from source 0 only, normal gated by the stack top
    always_comb begin
        fiq_o = req[0];
        irq_o = found && (empty || best_lvl > top_lvl);
    end

    // Read data mux
    always_comb begin
        rdata_o = '0;
        if (cfg_sel)
            rdata_o = cfg_q[addr_i[SRC_W-1:0]];
        else if (addr_i == A_VEC)
            rdata_o = irq_o ? CFG_W'(cfg_q[sel][VEC_W-1:0]) : CFG_W'(spur_q);
        else if (addr_i == A_FVEC)
            rdata_o = CFG_W'(cfg_q[0][VEC_W-1:0]);
        else if (addr_i == A_SPUR)
            rdata_o = CFG_W'(spur_q);
    end

    p_irq_src_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cfg_q[sel][EN_BIT]);
    p_irq_not_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> sel != '0);
    p_pick_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> pend[sel]);
endmodule

// File: tb/vpic_top_tb.sv
module vpic_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [13:0] wdata = '0;
    logic [13:0] rdata;
    logic        fiq, irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    localparam logic [5:0] A_VEC = 6'd32, A_EOI = 6'd33, A_FVEC = 6'd34, A_SPUR = 6'd35;

    always #10 clk = ~clk;

    vpic_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk); #1;
    endtask

    task automatic wr(logic [5:0] a, logic [13:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk); wr_en = 1'b0; #1;
    endtask

    task automatic rd(logic [5:0] a, output logic [13:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #2; d = rdata;
        @(posedge clk); @(negedge clk); rd_en = 1'b0; #1;
    endtask

    function automatic logic [13:0] cw(int idx, logic [2:0] lvl, logic [1:0] mode, logic en);
        return {en, mode, lvl, 8'h40 + 8'(idx)};
    endfunction

    task automatic cfg(int idx, logic [2:0] lvl, logic [1:0] mode, logic en);
        wr(6'(idx), cw(idx, lvl, mode, en));
    endtask

    task automatic t_reset();
        logic [13:0] d;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 fiq", 32'(fiq), 0);
        rd(6'd5, d);   chk("R1 cfg", 32'(d), 0);
        rd(A_SPUR, d); chk("R1 spur", 32'(d), 32'hFF);
        rd(A_VEC, d);  chk("R11 empty read", 32'(d), 32'hFF);
    endtask

    task automatic t_cfg();
        logic [13:0] d;
        wr(6'd7, 14'h2A5C); rd(6'd7, d); chk("R2 readback", 32'(d), 32'h2A5C);
        wr(6'd7, 14'h0);    rd(6'd7, d); chk("R2 clear", 32'(d), 0);
    endtask

    task automatic t_spurious();
        logic [13:0] d;
        wr(A_SPUR, 14'h005A);
        rd(A_VEC, d); chk("R11 spurious value", 32'(d), 32'h5A);
        cfg(9, 3'd0, 2'b00, 1'b1);
        src[9] = 1'b1; #1;
        chk("R11 nothing pushed", 32'(irq), 1);
        src[9] = 1'b0; cfg(9, 3'd0, 2'b00, 1'b0);
    endtask

    task automatic t_mask();
        logic [13:0] d;
        cfg(9, 3'd2, 2'b00, 1'b0);
        src[9] = 1'b1; tick();
        chk("R3 masked", 32'(irq), 0);
        cfg(9, 3'd2, 2'b00, 1'b1);
        chk("R3 unmasked", 32'(irq), 1);
        rd(A_VEC, d); chk("R8 vector", 32'(d), 32'h49);
        src[9] = 1'b0; wr(A_EOI, 0); cfg(9, 3'd0, 2'b00, 1'b0);
    endtask

    task automatic t_fast();
        logic [13:0] d;
        cfg(0, 3'd7, 2'b10, 1'b1);
        src[0] = 1'b1; tick();
        chk("R4 fiq set", 32'(fiq), 1);
        chk("R4 irq quiet", 32'(irq), 0);
        rd(A_VEC, d); chk("R4 not on normal", 32'(d), 32'h5A);
        rd(A_FVEC, d); chk("R4 fast vector", 32'(d), 32'h40);
        chk("R4 fiq cleared", 32'(fiq), 0);
        src[0] = 1'b0; cfg(0, 3'd0, 2'b00, 1'b0);
    endtask

    task automatic t_ext_modes();
        logic [13:0] d;
        src[1] = 1'b1; cfg(1, 3'd1, 2'b01, 1'b1);
        chk("R5 low level idle", 32'(irq), 0);
        src[1] = 1'b0; #1;
        chk("R5 low level active", 32'(irq), 1);
        cfg(1, 3'd1, 2'b01, 1'b0);
        src[2] = 1'b1; cfg(2, 3'd1, 2'b11, 1'b1); tick();
        chk("R5 falling idle", 32'(irq), 0);
        src[2] = 1'b0; tick();
        chk("R5 falling latched", 32'(irq), 1);
        rd(A_VEC, d); chk("R5 falling vector", 32'(d), 32'h42);
        wr(A_EOI, 0);
        chk("R8 edge cleared", 32'(irq), 0);
        cfg(2, 3'd0, 2'b00, 1'b0);
        cfg(3, 3'd1, 2'b00, 1'b1);
        src[3] = 1'b1; #1; chk("R5 high level", 32'(irq), 1);
        src[3] = 1'b0; #1; chk("R5 high level drop", 32'(irq), 0);
        cfg(3, 3'd0, 2'b00, 1'b0);
        cfg(4, 3'd1, 2'b10, 1'b1);
        src[4] = 1'b1; tick(); chk("R5 rising latched", 32'(irq), 1);
        src[4] = 1'b0; tick(); chk("R5 rising held", 32'(irq), 1);
        rd(A_VEC, d); wr(A_EOI, 0);
        chk("R5 rising acked", 32'(irq), 0);
        cfg(4, 3'd0, 2'b00, 1'b0);
    endtask

    task automatic t_internal();
        cfg(20, 3'd1, 2'b01, 1'b1);
        chk("R6 low input idle", 32'(irq), 0);
        src[20] = 1'b1; #1;
        chk("R6 high active", 32'(irq), 1);
        src[20] = 1'b0; cfg(20, 3'd0, 2'b00, 1'b0);
    endtask

    task automatic t_priority();
        logic [13:0] d;
        cfg(6, 3'd3, 2'b00, 1'b1);
        cfg(8, 3'd5, 2'b00, 1'b1);
        cfg(7, 3'd5, 2'b00, 1'b1);
        src[8:6] = 3'b111; #1;
        rd(A_VEC, d); chk("R7 level and tie", 32'(d), 32'h47);
        chk("R9 equal level blocked", 32'(irq), 0);
        wr(A_EOI, 0);
        chk("R10 restored", 32'(irq), 1);
        src[8:6] = 3'b000;
        for (int i = 6; i <= 8; i++) cfg(i, 3'd0, 2'b00, 1'b0);
    endtask

    task automatic t_nest();
        logic [13:0] d;
        for (int k = 0; k < 8; k++) cfg(5 + k, 3'(k), 2'b00, 1'b1);
        for (int k = 0; k < 8; k++) begin
            src[5 + k] = 1'b1; #1;
            chk("R9 higher preempts", 32'(irq), 1);
            rd(A_VEC, d); chk("R8 nested vector", 32'(d), 32'h45 + 32'(k));
        end
        chk("R9 full depth blocked", 32'(irq), 0);
        wr(A_EOI, 0);
        chk("R10 pop re-arms top", 32'(irq), 1);
        rd(A_VEC, d); chk("R8 re-ack", 32'(d), 32'h4C);
        src = '0;
        for (int k = 0; k < 9; k++) wr(A_EOI, 0);
        for (int k = 0; k < 8; k++) cfg(5 + k, 3'd0, 2'b00, 1'b0);
        cfg(10, 3'd0, 2'b00, 1'b1);
        src[10] = 1'b1; #1;
        chk("R10 stack empty again", 32'(irq), 1);
        src[10] = 1'b0; cfg(10, 3'd0, 2'b00, 1'b0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        t_reset();
        t_cfg();
        t_spurious();
        t_mask();
        t_fast();
        t_ext_modes();
        t_internal();
        t_priority();
        t_nest();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule